// File: doc/BRIEF.md
# Byte-Wide SPI Master Peripheral

This block is a register-mapped serial peripheral interface master for a byte-wide processor bus. Software writes a byte into the transmit register. The block shifts that byte out on MOSI while it shifts a byte in from MISO. It produces the serial clock by dividing the system clock by an even ratio. Software picks the clock idle level, the clock phase and the bit order in one shared control/status register.

The same register also reports four sticky flags: transfer finished, transmit slot free, receive byte waiting, and receive overrun. Each flag clears as a side effect of a particular bus access, so a polling driver needs no separate acknowledge writes. Once the shifter takes the transmit byte, the transmit slot is free again. Software can then queue the next byte while the current one is still shifting, and the transfers run back to back.

The bus port is synchronous. It has a 2-bit address, a write strobe and a read strobe. Read data is combinational from the address, and the clearing side effect of a read takes place on the clock edge at which the read strobe is high. Address 0 is the control/status register, address 1 is the transmit register (it reads as 0x00) and address 2 is the receive register.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, the control/status register reads 0x10 (only the transmit-free flag set), the receive register reads 0x00 and `sclk` is low.
- R2: The control/status bits are: bit7 LSB-first, bit6 overrun, bit5 complete, bit4 transmit free, bit3 receive full, bit2 phase, bit1 polarity, bit0 enable. Only bits 7, 2, 1 and 0 are writable. Written values of bits 6..3 are ignored.
- R3: With bit7 = 0 the byte goes out most significant bit first. With bit7 = 1 it goes out least significant bit first. Received bits are assembled in the same order.
- R4: With no transfer running, `sclk` sits at the polarity bit: low for 0, high for 1.
- R5: With phase = 0, data changes on the trailing edge of each clock pulse and is sampled on the leading edge. With phase = 1, data changes on the leading edge and is sampled on the trailing edge.
- R6: The complete flag is 0 while a transfer runs and becomes 1 when the eighth bit finishes. Any read of the control/status register clears it.
- R7: A transmit-register write clears the transmit-free flag. The flag returns to 1 when the shifter takes the byte, so a second byte can be queued for a back-to-back transfer.
- R8: At the end of a transfer, the received byte is loaded into the receive register and the receive-full flag is set. Reading the receive register clears the flag.
- R9: If a transfer ends while the receive-full flag is still set, the overrun flag is set. It stays set until the control/status register is read.
- R10: With enable = 0, no transfer starts, a pending byte waits, and `sclk` holds its idle level. Once enable is set, the pending byte is sent.
- R11: Each `sclk` half period lasts CLK_DIV/2 system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select (0 control/status, 1 transmit, 2 receive) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read side effects occur on the strobed edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest state to reach is a transfer ending while the previous received byte is still unread, together with a second byte queued behind a running transfer. The bench reaches both by using only status polls, which never touch the receive register. It watches the transmit-free flag come back during a running transfer and writes the next byte at once. All four clock modes are run in both bit orders against a slave model in the bench. That model drives MISO and captures MOSI on the edges chosen by the requirements, so an error in phase or order appears as a wrong byte on one side or the other.

// File: rtl/spi_m_pkg.sv
package spi_m_pkg;
  localparam int DW = 8;
  localparam int AW = 2;

  localparam logic [AW-1:0] A_CTRL = 2'd0;
  localparam logic [AW-1:0] A_TX   = 2'd1;
  localparam logic [AW-1:0] A_RX   = 2'd2;

  // Writable configuration fields
  typedef struct packed {
    logic lsb_first;
    logic cpha;
    logic cpol;
    logic en;
  } cfg_t;

  // Sticky status flags
  typedef struct packed {
    logic ovr;
    logic cmpl;
    logic tx_free;
    logic rx_full;
  } stat_t;
endpackage

// File: rtl/spi_m_divider.sv
module spi_m_divider #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == CNT_LAST);
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_m_shifter.sv
module spi_m_shifter
  import spi_m_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  cfg_t          cfg,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          tick,
  input  logic          miso,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_byte,
  output logic          sclk,
  output logic          mosi
);
  localparam int EDGES  = 2 * DW;
  localparam int EDGE_W = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  logic              busy_q, busy_d;
  logic              sclk_q, sclk_d;
  logic [EDGE_W-1:0] edge_q, edge_d;
  logic [DW-1:0]     tx_q, tx_d;
  logic [DW-1:0]     rx_q, rx_d;

  logic          lead, sample_now, shift_now, last;
  logic [DW-1:0] rx_shifted, tx_shifted;

  always_comb begin
    lead       = ~edge_q[0];
    last       = busy_q && tick && (edge_q == LAST_EDGE);
    sample_now = busy_q && tick && (cfg.cpha ? !lead : lead);
    shift_now  = busy_q && tick &&
                 (cfg.cpha ? (lead && edge_q != '0) : (!lead && edge_q != LAST_EDGE));
    rx_shifted = cfg.lsb_first ? {miso, rx_q[DW-1:1]} : {rx_q[DW-2:0], miso};
    tx_shifted = cfg.lsb_first ? {1'b0, tx_q[DW-1:1]} : {tx_q[DW-2:0], 1'b0};
  end

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    edge_d = edge_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    if (!cfg.en) begin
      busy_d = 1'b0;
      sclk_d = 1'b0;
      edge_d = '0;
    end else if (load) begin
      busy_d = 1'b1;
      sclk_d = 1'b0;
      edge_d = '0;
      tx_d   = load_data;
    end else if (busy_q && tick) begin
      sclk_d = ~sclk_q;
      edge_d = edge_q + 1'b1;
      if (sample_now) rx_d = rx_shifted;
      if (shift_now)  tx_d = tx_shifted;
      if (last) begin
        busy_d = 1'b0;
        edge_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      edge_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      edge_q <= edge_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign done    = last && cfg.en;
  assign rx_byte = sample_now ? rx_shifted : rx_q;
  assign sclk    = sclk_q ^ cfg.cpol;
  assign mosi    = cfg.lsb_first ? tx_q[0] : tx_q[DW-1];
endmodule

// File: rtl/spi_m_regs.sv
module spi_m_regs
  import spi_m_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  input  logic          busy,
  input  logic          done,
  input  logic [DW-1:0] rx_byte,
  output cfg_t          cfg,
  output stat_t         stat,
  output logic [DW-1:0] rx_data,
  output logic          load,
  output logic [DW-1:0] tx_data
);
  cfg_t          cfg_q, cfg_d;
  stat_t         st_q, st_d;
  logic [DW-1:0] txh_q, txh_d;
  logic [DW-1:0] rxd_q, rxd_d;
  logic          wr_ctrl, wr_tx, rd_ctrl, rd_rx;

  always_comb begin
    wr_ctrl = wr && (addr == A_CTRL);
    wr_tx   = wr && (addr == A_TX);
    rd_ctrl = rd && (addr == A_CTRL);
    rd_rx   = rd && (addr == A_RX);
    load    = cfg_q.en && !busy && !st_q.tx_free;
  end

  always_comb begin
    cfg_d = cfg_q;
    st_d  = st_q;
    txh_d = txh_q;
    rxd_d = rxd_q;

    if (wr_ctrl) begin
      cfg_d.lsb_first = wdata[7];
      cfg_d.cpha      = wdata[2];
      cfg_d.cpol      = wdata[1];
      cfg_d.en        = wdata[0];
    end

    if (wr_tx) begin
      txh_d      = wdata;
      st_d.tx_free = 1'b0;
    end else if (load) begin
      st_d.tx_free = 1'b1;
    end

    if (done)          st_d.cmpl = 1'b1;
    else if (load)     st_d.cmpl = 1'b0;
    else if (rd_ctrl)  st_d.cmpl = 1'b0;

    if (done) begin
      rxd_d        = rx_byte;
      st_d.rx_full = 1'b1;
    end else if (rd_rx) begin
      st_d.rx_full = 1'b0;
    end

    if (done && st_q.rx_full && !rd_rx) st_d.ovr = 1'b1;
    else if (rd_ctrl)                   st_d.ovr = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      st_q  <= '{ovr: 1'b0, cmpl: 1'b0, tx_free: 1'b1, rx_full: 1'b0};
      txh_q <= '0;
      rxd_q <= '0;
    end else begin
      cfg_q <= cfg_d;
      st_q  <= st_d;
      txh_q <= txh_d;
      rxd_q <= rxd_d;
    end
  end

  assign cfg     = cfg_q;
  assign stat    = st_q;
  assign rx_data = rxd_q;
  assign tx_data = txh_q;
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_m_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso
);
  cfg_t          cfg_w;
  stat_t         stat_w;
  logic [DW-1:0] rx_data_w, tx_data_w, rx_byte_w;
  logic          eng_busy, eng_done, eng_load, eng_tick;

  spi_m_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (bus_addr),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .wdata   (bus_wdata),
    .busy    (eng_busy),
    .done    (eng_done),
    .rx_byte (rx_byte_w),
    .cfg     (cfg_w),
    .stat    (stat_w),
    .rx_data (rx_data_w),
    .load    (eng_load),
    .tx_data (tx_data_w)
  );

  spi_m_divider #(.CLK_DIV(CLK_DIV)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (eng_busy),
    .tick  (eng_tick)
  );

  spi_m_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg_w),
    .load      (eng_load),
    .load_data (tx_data_w),
    .tick      (eng_tick),
    .miso      (miso),
    .busy      (eng_busy),
    .done      (eng_done),
    .rx_byte   (rx_byte_w),
    .sclk      (sclk),
    .mosi      (mosi)
  );

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {cfg_w.lsb_first, stat_w.ovr, stat_w.cmpl, stat_w.tx_free,
                            stat_w.rx_full, cfg_w.cpha, cfg_w.cpol, cfg_w.en};
      A_RX:    bus_rdata = rx_data_w;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk
  import spi_m_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic          sclk,
  input cfg_t          cfg_w,
  input stat_t         stat_w,
  input logic          eng_busy,
  input logic          eng_done,
  input logic          eng_load
);
  // R2
  status_ignores_ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTRL && !bus_rd && !eng_done && !eng_load) |=> $stable(stat_w));

  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |-> (sclk == cfg_w.cpol));

  // R6
  busy_not_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !stat_w.cmpl);

  // R6
  ctrl_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_CTRL && !eng_done) |=> !stat_w.cmpl);

  // R7
  tx_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_TX) |=> !stat_w.tx_free);

  // R8
  done_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> stat_w.rx_full);

  // R8
  rx_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_RX && !eng_done) |=> !stat_w.rx_full);

  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && stat_w.rx_full && !(bus_rd && bus_addr == A_RX)) |=> stat_w.ovr);

  // R10
  load_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_load |-> cfg_w.en);
endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .sclk     (sclk),
  .cfg_w    (cfg_w),
  .stat_w   (stat_w),
  .eng_busy (eng_busy),
  .eng_done (eng_done),
  .eng_load (eng_load)
);

// File: tb/spi_byte_master_tb.sv
`timescale 1ns/1ps
module spi_byte_master_tb;
  localparam int CLK_DIV = 4;
  localparam int HALF_NS = 20 * CLK_DIV / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       sclk, mosi;
  logic       miso = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  spi_byte_master #(.CLK_DIV(CLK_DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  // Mode as configured by the bench
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Scoreboard queues
  logic [7:0] exp_mosi[$];
  logic [7:0] slv_q[$];

  // Slave model
  logic       s_arm = 1'b0;
  int         s_edges = 0, s_samp = 0;
  logic [7:0] s_cur = '0, s_rx = '0;
  time        s_last = 0;
  bit         s_perr = 1'b0;

  function automatic int pos(input int k);
    return cfg_lsb ? k : 7 - k;
  endfunction

  task automatic slave_arm();
    s_edges = 0; s_samp = 0; s_perr = 1'b0;
    s_cur = slv_q.pop_front();
    miso = s_cur[pos(0)];
    s_arm = 1'b1;
  endtask

  // Monitor: pops expected MOSI bytes as the slave completes frames
  always @(sclk) begin
    if (s_arm) begin
      automatic bit lead = (sclk != cfg_cpol);
      if (s_edges > 0 && (($time - s_last) != HALF_NS)) s_perr = 1'b1;
      s_last = $time;
      if (cfg_cpha) begin
        if (lead) miso = s_cur[pos(s_edges / 2)];
        else begin s_rx[pos(s_samp)] = mosi; s_samp++; end
      end else begin
        if (lead) begin s_rx[pos(s_samp)] = mosi; s_samp++; end
        else if (s_edges < 15) miso = s_cur[pos((s_edges + 1) / 2)];
      end
      s_edges++;
      if (s_edges == 16) begin
        if (exp_mosi.size() == 0) chk(1'b0, "R3 unexpected frame", s_rx, 0);
        else begin
          automatic logic [7:0] e = exp_mosi.pop_front();
          chk(s_rx == e, "R3/R5 mosi byte", s_rx, e);
        end
        chk(!s_perr, "R11 half period", s_perr, 0);
        s_edges = 0; s_samp = 0; s_perr = 1'b0;
        if (slv_q.size() > 0) begin
          s_cur = slv_q.pop_front();
          miso = s_cur[pos(0)];
        end else s_arm = 1'b0;
      end
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic set_cfg(input bit lsb, input bit cpha, input bit cpol, input bit en);
    cfg_lsb = lsb; cfg_cpha = cpha; cfg_cpol = cpol;
    bus_write(2'd0, {lsb, 4'b0000, cpha, cpol, en});
  endtask

  task automatic wait_done(output logic [7:0] st);
    st = '0;
    for (int i = 0; i < 2000; i++) begin
      bus_read(2'd0, st);
      if (st[5]) return;
    end
    chk(1'b0, "R6 complete timeout", st, 8'h20);
  endtask

  // Driver: one transfer in the given mode
  task automatic do_xfer(input bit lsb, input bit cpha, input bit cpol,
                         input logic [7:0] txb, input logic [7:0] slvb);
    logic [7:0] st, rx;
    s_arm = 1'b0;
    set_cfg(lsb, cpha, cpol, 1'b1);
    @(negedge clk);
    chk(sclk == cpol, "R4 idle level", sclk, cpol);
    slv_q.push_back(slvb);
    slave_arm();
    exp_mosi.push_back(txb);
    bus_write(2'd1, txb);
    wait_done(st);
    chk(st[3] == 1'b1, "R8 rx full after transfer", st, 8'h08);
    bus_read(2'd2, rx);
    chk(rx == slvb, "R3/R5 received byte", rx, slvb);
  endtask

  initial begin
    logic [7:0] st, rx;
    int toggles;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(2'd0, st);
    chk(st == 8'h10, "R1 ctrl reset", st, 8'h10);
    bus_read(2'd2, rx);
    chk(rx == 8'h00, "R1 rx reset", rx, 8'h00);
    chk(sclk == 1'b0, "R1 sclk reset", sclk, 0);

    // R2 writable bits
    bus_write(2'd0, 8'h78);
    bus_read(2'd0, st);
    chk(st == 8'h10, "R2 status bits ignore write", st, 8'h10);
    bus_write(2'd0, 8'hFF);
    bus_read(2'd0, st);
    chk(st == 8'h97, "R2 writable bits", st, 8'h97);
    bus_write(2'd0, 8'h00);
    bus_read(2'd0, st);
    chk(st == 8'h10, "R2 clear writable", st, 8'h10);

    // R10 disabled: byte waits, clock idle high (polarity 1)
    set_cfg(1'b0, 1'b0, 1'b1, 1'b0);
    bus_write(2'd1, 8'h5A);
    toggles = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sclk != 1'b1) toggles++;
    end
    chk(toggles == 0, "R10 sclk held while disabled", toggles, 0);
    bus_read(2'd0, st);
    chk(st == 8'h02, "R10/R7 pending, no start", st, 8'h02);

    // Enable: pending byte goes out
    slv_q.push_back(8'hC3);
    slave_arm();
    exp_mosi.push_back(8'h5A);
    bus_write(2'd0, 8'h03);
    bus_read(2'd0, st);
    chk(st[5:4] == 2'b01, "R6/R7 in progress, slot free", st[5:4], 2'b01);
    wait_done(st);
    chk(st[5] && st[3], "R6/R8 complete and full", st, 8'h28);
    bus_read(2'd0, st);
    chk(st[5] == 1'b0, "R6 cleared by ctrl read", st, 0);
    bus_read(2'd2, rx);
    chk(rx == 8'hC3, "R8 rx byte", rx, 8'hC3);
    bus_read(2'd0, st);
    chk(st[3] == 1'b0, "R8 cleared by rx read", st, 0);

    // All modes, both orders
    for (int m = 0; m < 8; m++) begin
      automatic logic [7:0] t = 8'h35 + 8'(m) * 8'h29;
      automatic logic [7:0] s = ~t ^ 8'(m * 3);
      do_xfer(m[2], m[1], m[0], t, s);
    end

    // R9 overrun
    s_arm = 1'b0;
    set_cfg(1'b0, 1'b0, 1'b0, 1'b1);
    slv_q.push_back(8'hA1); slv_q.push_back(8'h3E);
    slave_arm();
    exp_mosi.push_back(8'h11);
    bus_write(2'd1, 8'h11);
    wait_done(st);
    chk(st[6] == 1'b0, "R9 no overrun on first", st, 0);
    exp_mosi.push_back(8'h22);
    bus_write(2'd1, 8'h22);
    wait_done(st);
    chk(st[6] && st[3], "R9 overrun set", st, 8'h48);
    bus_read(2'd0, st);
    chk(st[6] == 1'b0, "R9 overrun cleared by ctrl read", st, 0);
    bus_read(2'd2, rx);
    chk(rx == 8'h3E, "R9 rx holds newest", rx, 8'h3E);

    // R7 back-to-back
    s_arm = 1'b0;
    set_cfg(1'b1, 1'b1, 1'b0, 1'b1);
    slv_q.push_back(8'h6D); slv_q.push_back(8'h92);
    slave_arm();
    exp_mosi.push_back(8'hE7); exp_mosi.push_back(8'h18);
    bus_write(2'd1, 8'hE7);
    bus_read(2'd0, st);
    chk(st[4] == 1'b1 && st[5] == 1'b0, "R7 slot free during transfer", st, 8'h10);
    bus_write(2'd1, 8'h18);
    bus_read(2'd0, st);
    chk(st[4] == 1'b0, "R7 second byte queued", st, 0);
    wait_done(st);
    wait_done(st);
    bus_read(2'd2, rx);
    chk(rx == 8'h92, "R7 second received byte", rx, 8'h92);
    repeat (4) @(negedge clk);
    chk(exp_mosi.size() == 0, "R3 all frames seen", exp_mosi.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule